// File: doc/BRIEF.md
# Interrupt Status Aggregation Register

This block collects a set of interrupt sources into one status register that the host can see, and it drives one interrupt request line toward the host. Most sources are edge-sensitive. A rising edge on such an input sets a sticky status bit, and that bit holds until software clears it. One more bit summarises a bank of GPIO sticky flags. This bit is level-sensitive: while any flag in the bank is true, the bit is set, and a clear from software cannot hold it down.

Software reaches the block through a small register port made of an address, a write strobe, write data and combinational read data. The status register sits at address 0. Writing a 1 to a status bit clears that bit, and writing a 0 leaves it alone. A read/write enable mask sits at address 1. The interrupt line is asserted whenever some status bit is set and its enable bit is also set. The GPIO pin logic, the DMA engines and the host bus protocol all live outside this block. The GPIO flags arrive here as plain inputs.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, the status register, the mask register and `irq` are all 0.
- R2: When edge input `edge_src[i]` rises, status bit i (address 0) is set on the clock edge that samples the rise. The bit is readable from the following cycle.
- R3: An edge status bit holds while no clear is written, even after its input falls. If the bit is cleared while its input stays high, it remains 0 until a new rising edge arrives.
- R4: A write to address 0 clears every status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R5: Status bit N_EDGE (bit 8 by default) is set whenever any bit of `gpio_sticky` is 1. If this bit is cleared while any GPIO flag is still 1, it reads 1 again in the next cycle. If it is cleared while all GPIO flags are 0, it stays 0.
- R6: If a rising edge and a write-1-clear reach the same bit in the same cycle, the bit ends up set.
- R7: `irq` equals the OR over all bits of (status AND mask). The mask is read and written at address 1, and mask bit positions match status bit positions.
- R8: Reading has no side effects. Repeated reads return the same value when no stimulus occurs between them.
- R9: Bits above N_EDGE read as 0 at addresses 0 and 1, and writes to those bits have no effect. Addresses 2 and 3 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edge_src | input | N_EDGE | Edge-sensitive interrupt inputs |
| gpio_sticky | input | N_GPIO | Per-pin GPIO sticky flags, combined into the level-sensitive bit |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational from the address |
| irq | output | 1 | Interrupt request to the host |

## Verification
Every status update is a single register stage. A rise on an edge input, a change on a GPIO flag, or a write-1-clear is visible on `rdata` and `irq` exactly one clock after the edge that samples it. Reads and the mask gating are combinational from the registers. The bench therefore drives inputs just after a rising edge and checks just after the next one. This makes it possible to observe the cycle where a GPIO-held bit reasserts and the cycle where a set beats a clear. The bench sweeps every edge input, all GPIO patterns of a 4-bit bank, and each mask bit on its own.

// File: rtl/irq_status_agg.sv
module irq_status_agg #(
  parameter int N_EDGE = 8,
  parameter int N_GPIO = 4,
  parameter int AW     = 2,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EDGE-1:0] edge_src,
  input  logic [N_GPIO-1:0] gpio_sticky,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq
);
  localparam int NS = N_EDGE + 1;
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_MASK = AW'(1);

  logic [N_EDGE-1:0] prev_q, edge_q, rise;
  logic              gpio_q;
  logic [NS-1:0]     mask_q, clr, status;

  assign rise   = edge_src & ~prev_q;
  assign clr    = (wr_en && addr == A_STAT) ? wdata[NS-1:0] : '0;
  assign status = {gpio_q, edge_q};
  assign irq    = |(status & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      edge_q <= '0;
      gpio_q <= 1'b0;
      mask_q <= '0;
    end else begin
      prev_q <= edge_src;
      edge_q <= rise | (edge_q & ~clr[N_EDGE-1:0]);
      gpio_q <= (|gpio_sticky) | (gpio_q & ~clr[N_EDGE]);
      if (wr_en && addr == A_MASK) mask_q <= wdata[NS-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT:  rdata[NS-1:0] = status;
      A_MASK:  rdata[NS-1:0] = mask_q;
      default: rdata = '0;
    endcase
  end

  // R3
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_STAT) |=> (($past(status) & ~status) == '0));

  // R4
  zero_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT) |=> ((($past(status) & ~$past(wdata[NS-1:0])) & ~status) == '0));

  // R5
  gpio_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gpio_sticky) |=> status[N_EDGE]);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((edge_q & $past(rise)) == $past(rise)));

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0 || status == '0) |-> !irq);

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:NS] == '0);
endmodule

// File: tb/irq_status_agg_bench.sv
module irq_status_agg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8, NG = 4, AW = 2, DW = 16;
  localparam int GB = NE;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [NE-1:0] edge_src = '0;
  logic [NG-1:0] gpio_sticky = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata, snap;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  irq_status_agg #(.N_EDGE(NE), .N_GPIO(NG), .AW(AW), .DW(DW)) u_irq_status_agg (
    .clk(clk), .rst_n(rst_n), .edge_src(edge_src), .gpio_sticky(gpio_sticky),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic rd(input int a, input int exp, input string req);
    addr = AW'(a); #1;
    chk(rdata == DW'(exp), req, int'(rdata), exp);
  endtask

  task automatic wr(input int a, input int d);
    addr = AW'(a); wdata = DW'(d); wr_en = 1; step(); wr_en = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_up();
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    // R1 reset state
    rd(0, 0, "R1 status"); rd(1, 0, "R1 mask");
    chk(irq == 0, "R1 irq", irq, 0);

    // R2 each edge input sets its own bit; R4 clear
    for (int i = 0; i < NE; i++) begin
      edge_src = NE'(1) << i; step(); edge_src = '0;
      rd(0, 1 << i, "R2 edge set");
      step(); rd(0, 1 << i, "R3 held after fall");
      wr(0, 1 << i); rd(0, 0, "R4 cleared");
    end

    // R4 zeros keep bits
    edge_src = '1; step(); edge_src = '0;
    wr(0, 'h0F); rd(0, 'hF0, "R4 zero keeps");
    wr(0, 'hFFFF); rd(0, 0, "R4 clear all");

    // R3 held-high input does not re-set after clear
    edge_src = NE'(1) << 2; step(); rd(0, 4, "R2 set bit2");
    wr(0, 4); step(); rd(0, 0, "R3 no re-set while high");
    edge_src = '0; step(); edge_src = NE'(1) << 2; step();
    rd(0, 4, "R3 new edge sets");
    edge_src = '0; wr(0, 4);

    // R6 set beats clear in same cycle
    edge_src = NE'(1) << 3; wdata = DW'(1 << 3); addr = 0; wr_en = 1; step(); wr_en = 0;
    edge_src = '0; rd(0, 8, "R6 set wins");
    wr(0, 8); rd(0, 0, "R6 then clears");

    // R5 GPIO level-sensitive bit over all patterns
    for (int p = 0; p < (1 << NG); p++) begin
      gpio_sticky = NG'(p); step();
      rd(0, (p != 0) << GB, "R5 gpio set");
      wr(0, 1 << GB);
      rd(0, (p != 0) << GB, "R5 reassert after clear");
      gpio_sticky = '0; wr(0, 1 << GB);
      rd(0, 0, "R5 stays clear");
    end

    // R7 per-bit masking
    edge_src = '1; gpio_sticky = 1; step(); edge_src = '0; gpio_sticky = 0;
    rd(0, 'h1FF, "R7 all set");
    chk(irq == 0, "R7 mask zero", irq, 0);
    for (int b = 0; b <= NE; b++) begin
      wr(1, 1 << b); rd(1, 1 << b, "R7 mask readback");
      chk(irq == 1, "R7 irq on", irq, 1);
      wr(0, 1 << b);
      chk(irq == 0, "R7 irq off after clear", irq, 0);
    end
    wr(1, 'h1FF); chk(irq == 0, "R7 nothing pending", irq, 0);

    // R8 reads have no side effects
    edge_src = 'h21; step(); edge_src = '0;
    rd(0, 'h21, "R8 first read"); snap = rdata;
    rd(1, 'h1FF, "R8 other addr"); step();
    rd(0, int'(snap), "R8 second read");
    chk(irq == 1, "R8 irq kept", irq, 1);

    // R9 unused bits and addresses
    wr(1, 'hFFFF); rd(1, 'h1FF, "R9 mask upper");
    wr(2, 'hFFFF); rd(2, 0, "R9 addr2"); rd(3, 0, "R9 addr3");
    rd(0, 'h21, "R9 addr2 write no effect");
    wr(0, 'hFE00); rd(0, 'h21, "R9 upper write no effect");
    finish_up();
  end
endmodule